// File: doc/BRIEF.md
# Debug Memory Access Bus Arbiter

This block lends the processor's local bus to a debug command unit for a single memory access while the core keeps executing. When the debug unit raises its request, the arbiter first stalls the core's instruction fetch. It then waits until the bus cycle the core already has in flight has finished. Only then does it hand the bus to the debug unit for one access of fixed length, after which it gives ownership back to the core without further action from either side.

The grant output drives the select of the bus multiplexer: low selects the core, high selects the debug unit. The fetch stall stays up from the moment a request is taken until a short hand-back window has elapsed. A request that is still held after the access is taken up again only after the arbiter has spent a cycle idle, so the core always owns the bus for at least one cycle between two debug accesses. Register-access debug commands, command decoding and the memory itself lie outside this block.

Parameters: `ACC_LEN` is the number of cycles the debug unit holds the bus, `REL_LEN` is the number of hand-back cycles during which the stall is kept after the grant drops, and `ACK_REG` chooses whether the acknowledge pulse is driven in the last grant cycle (0) or one cycle later (1).

Top module: `lbus_dbg_arb`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `fetch_stall`, `bus_sel_dbg` and `dbg_ack` are all 0.
- R2: While the arbiter is idle and `dbg_req` is 0, `cpu_busy` has no effect: `fetch_stall`, `bus_sel_dbg` and `dbg_ack` stay 0.
- R3: A `dbg_req` of 1 sampled at a clock edge while idle raises `fetch_stall` in the following cycle, with `bus_sel_dbg` still 0.
- R4: While stalled and not yet granted, each edge that samples `cpu_busy` = 1 keeps `bus_sel_dbg` at 0. `bus_sel_dbg` becomes 1 in the cycle after the first edge that samples `cpu_busy` = 0.
- R5: `bus_sel_dbg` stays 1 for exactly `ACC_LEN` consecutive cycles per access.
- R6: `dbg_ack` is a single-cycle pulse per access. With `ACK_REG` = 0 it is high in the last cycle in which `bus_sel_dbg` is 1. With `ACK_REG` = 1 it is high in the first cycle after that.
- R7: After `bus_sel_dbg` falls, `fetch_stall` stays 1 for exactly `REL_LEN` more cycles and then drops to 0.
- R8: A `dbg_req` still held during the access or hand-back is not taken up again until `fetch_stall` has been 0 for exactly one cycle.
- R9: `bus_sel_dbg` is never 1 while `fetch_stall` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_req | input | 1 | Debug unit asks for one bus access; held until acknowledged |
| cpu_busy | input | 1 | Core has a bus cycle in progress |
| fetch_stall | output | 1 | Holds the core's instruction fetch pipeline |
| bus_sel_dbg | output | 1 | Bus multiplexer select: 1 = debug unit, 0 = core |
| dbg_ack | output | 1 | One-cycle pulse on completion of the debug access |

## Verification
The bench builds the arbiter with `ACC_LEN` = 3, `REL_LEN` = 2 and `ACK_REG` = 0. With these values, the access window, the hand-back window and the acknowledge position can each be told apart from their neighbours by a single cycle. The bench sweeps the length of the core's in-flight bus cycle from 0 to 8 cycles, both with the request dropped on acknowledge and with it held, and predicts every output in every cycle from the window arithmetic. It also covers idle activity on `cpu_busy` and a reset applied in the middle of an access.

// File: rtl/lbus_dbg_arb_pkg.sv
package lbus_dbg_arb_pkg;

   typedef enum logic [1:0] {
      ARB_IDLE  = 2'd0,
      ARB_DRAIN = 2'd1,
      ARB_DBG   = 2'd2,
      ARB_HAND  = 2'd3
   } arb_state_e;

   function automatic int max_len(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lbus_dbg_arb_tmr.sv
module lbus_dbg_arb_tmr #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/lbus_dbg_arb_fsm.sv
module lbus_dbg_arb_fsm
   import lbus_dbg_arb_pkg::*;
#(
   parameter int               CNT_W    = 2,
   parameter logic [CNT_W-1:0] ACC_LAST = '0,
   parameter logic [CNT_W-1:0] REL_LAST = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             busy,
   input  logic             win_zero,
   output arb_state_e       state,
   output logic             win_load,
   output logic [CNT_W-1:0] win_val
);
   arb_state_e state_q, state_d;

   always_comb begin
      state_d  = state_q;
      win_load = 1'b0;
      win_val  = '0;
      case (state_q)
         ARB_IDLE: begin
            if (req) state_d = ARB_DRAIN;
         end
         ARB_DRAIN: begin
            // the core's in-flight cycle must end before handover
            if (!busy) begin
               state_d  = ARB_DBG;
               win_load = 1'b1;
               win_val  = ACC_LAST;
            end
         end
         ARB_DBG: begin
            if (win_zero) begin
               state_d  = ARB_HAND;
               win_load = 1'b1;
               win_val  = REL_LAST;
            end
         end
         ARB_HAND: begin
            if (win_zero) state_d = ARB_IDLE;
         end
         default: state_d = ARB_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ARB_IDLE;
      else        state_q <= state_d;
   end

   assign state = state_q;
endmodule

// File: rtl/lbus_dbg_arb_ack.sv
module lbus_dbg_arb_ack #(
   parameter bit ACK_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic last_beat,
   output logic ack
);
   generate
      if (ACK_REG) begin : g_ack_flop
         logic ack_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ack_q <= 1'b0;
            else        ack_q <= last_beat;
         end
         assign ack = ack_q;
      end else begin : g_ack_comb
         assign ack = last_beat;
      end
   endgenerate
endmodule

// File: rtl/lbus_dbg_arb.sv
module lbus_dbg_arb
   import lbus_dbg_arb_pkg::*;
#(
   parameter int ACC_LEN = 2,
   parameter int REL_LEN = 1,
   parameter bit ACK_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dbg_req,
   input  logic cpu_busy,
   output logic fetch_stall,
   output logic bus_sel_dbg,
   output logic dbg_ack
);
   localparam int               WIN_MAX  = max_len(ACC_LEN, REL_LEN);
   localparam int               CNT_W    = $clog2(WIN_MAX + 1);
   localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACC_LEN - 1);
   localparam logic [CNT_W-1:0] REL_LAST = CNT_W'(REL_LEN - 1);

   generate
      if (ACC_LEN < 1) begin : g_bad_acc
         $error("ACC_LEN must be at least 1");
      end
      if (REL_LEN < 1) begin : g_bad_rel
         $error("REL_LEN must be at least 1");
      end
   endgenerate

   arb_state_e       state;
   logic             win_load;
   logic [CNT_W-1:0] win_val;
   logic             win_zero;

   lbus_dbg_arb_fsm #(
      .CNT_W   (CNT_W),
      .ACC_LAST(ACC_LAST),
      .REL_LAST(REL_LAST)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (dbg_req),
      .busy    (cpu_busy),
      .win_zero(win_zero),
      .state   (state),
      .win_load(win_load),
      .win_val (win_val)
   );

   lbus_dbg_arb_tmr #(
      .CNT_W(CNT_W)
   ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (win_load),
      .load_val(win_val),
      .zero    (win_zero)
   );

   lbus_dbg_arb_ack #(
      .ACK_REG(ACK_REG)
   ) u_ack (
      .clk      (clk),
      .rst_n    (rst_n),
      .last_beat((state == ARB_DBG) && win_zero),
      .ack      (dbg_ack)
   );

   assign fetch_stall = (state != ARB_IDLE);
   assign bus_sel_dbg = (state == ARB_DBG);
endmodule

// File: rtl/lbus_dbg_arb_chk.sv
module lbus_dbg_arb_chk #(
   parameter int ACC_LEN = 2,
   parameter int REL_LEN = 1,
   parameter bit ACK_REG = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic dbg_req,
   input logic cpu_busy,
   input logic fetch_stall,
   input logic bus_sel_dbg,
   input logic dbg_ack
);
   logic        rst_seen_q;
   logic        had_grant_q;
   logic [31:0] grant_run_q;
   logic [31:0] hand_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_seen_q  <= 1'b1;
         had_grant_q <= 1'b0;
         grant_run_q <= '0;
         hand_run_q  <= '0;
      end else begin
         rst_seen_q  <= 1'b0;
         had_grant_q <= fetch_stall && (had_grant_q || bus_sel_dbg);
         grant_run_q <= bus_sel_dbg ? grant_run_q + 1 : '0;
         hand_run_q  <= (fetch_stall && !bus_sel_dbg && had_grant_q) ? hand_run_q + 1 : '0;
      end
   end

   // R1
   always_ff @(negedge clk) begin
      if (rst_seen_q) begin
         reset_idle_chk: assert (!fetch_stall && !bus_sel_dbg && !dbg_ack);
      end
   end

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_stall && !dbg_req) |=> !fetch_stall);

   // R3
   req_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_stall && dbg_req) |=> (fetch_stall && !bus_sel_dbg));

   // R4
   drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_stall && !bus_sel_dbg && !had_grant_q && cpu_busy) |=> !bus_sel_dbg);

   // R4
   grant_after_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_sel_dbg) |-> ($past(!cpu_busy) && $past(fetch_stall)));

   // R5
   grant_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_sel_dbg) |-> (grant_run_q == 32'(ACC_LEN)));

   // R6
   ack_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_ack |-> (ACK_REG ? ($past(bus_sel_dbg) && !bus_sel_dbg) : (bus_sel_dbg && grant_run_q == 32'(ACC_LEN - 1))));

   // R7
   hand_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(fetch_stall) && had_grant_q) |-> (hand_run_q == 32'(REL_LEN)));

   // R8
   idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fetch_stall) |-> !bus_sel_dbg);

   // R9
   grant_needs_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel_dbg |-> fetch_stall);
endmodule

bind lbus_dbg_arb lbus_dbg_arb_chk #(
   .ACC_LEN(ACC_LEN),
   .REL_LEN(REL_LEN),
   .ACK_REG(ACK_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dbg_req    (dbg_req),
   .cpu_busy   (cpu_busy),
   .fetch_stall(fetch_stall),
   .bus_sel_dbg(bus_sel_dbg),
   .dbg_ack    (dbg_ack)
);

// File: tb/sim_lbus_dbg_arb.sv
`timescale 1ns/1ps
module sim_lbus_dbg_arb;
   localparam int ACC = 3;
   localparam int REL = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dbg_req = 1'b0;
   logic cpu_busy = 1'b0;
   logic fetch_stall, bus_sel_dbg, dbg_ack;

   int vectors = 0;
   int miscompares = 0;

   always #5 clk = ~clk;

   lbus_dbg_arb #(.ACC_LEN(ACC), .REL_LEN(REL), .ACK_REG(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .dbg_req(dbg_req), .cpu_busy(cpu_busy),
      .fetch_stall(fetch_stall), .bus_sel_dbg(bus_sel_dbg), .dbg_ack(dbg_ack)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   // n = clock edges since the request was driven, d = drain cycles
   function automatic logic exp_stall(input int n, input int d, input bit hold);
      if (hold && n == d + 3 + ACC + REL) return 1'b1;   // R8 retake
      return (n >= 1) && (n <= d + 1 + ACC + REL);
   endfunction

   function automatic logic exp_grant(input int n, input int d);
      return (n >= d + 2) && (n <= d + 1 + ACC);
   endfunction

   function automatic logic exp_ack(input int n, input int d);
      return (n == d + 1 + ACC);
   endfunction

   function automatic string tag_of(input int n, input int d, input bit hold);
      if (n == 1)                            return "R3";
      if (n <= d + 1)                        return "R4";
      if (n <= d + 1 + ACC)                  return "R5";
      if (n <= d + 1 + ACC + REL)            return "R7";
      if (hold)                              return "R8";
      return "R7";
   endfunction

   task automatic run_txn(input int d, input bit hold);
      int last;
      last = hold ? d + 3 + ACC + REL : d + 2 + ACC + REL;
      for (int n = 0; n <= last; n++) begin
         if (n == 0) begin
            chk("R2", "stall before request", fetch_stall, 1'b0);
            dbg_req  = 1'b1;
            cpu_busy = (d > 0);
         end else begin
            chk(tag_of(n, d, hold), "fetch_stall", fetch_stall, exp_stall(n, d, hold));
            chk(tag_of(n, d, hold), "bus_sel_dbg", bus_sel_dbg, exp_grant(n, d));
            chk("R6", "dbg_ack", dbg_ack, exp_ack(n, d));
            chk("R9", "grant implies stall", bus_sel_dbg && !fetch_stall, 1'b0);
            cpu_busy = (n <= d);
            if (!hold && n == d + 1 + ACC) dbg_req = 1'b0;
         end
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic do_reset();
      rst_n    = 1'b0;
      dbg_req  = 1'b0;
      cpu_busy = 1'b0;
      #1;
      chk("R1", "stall in reset", fetch_stall, 1'b0);
      chk("R1", "grant in reset", bus_sel_dbg, 1'b0);
      chk("R1", "ack in reset", dbg_ack, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "stall after reset", fetch_stall, 1'b0);
      chk("R1", "grant after reset", bus_sel_dbg, 1'b0);
   endtask

   initial begin
      #2_000_000;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();

      // R2: core bus activity alone never stalls or grants
      for (int i = 0; i < 8; i++) begin
         cpu_busy = i[0];
         @(posedge clk);
         @(negedge clk);
         chk("R2", "idle stall", fetch_stall, 1'b0);
         chk("R2", "idle grant", bus_sel_dbg, 1'b0);
         chk("R2", "idle ack", dbg_ack, 1'b0);
      end
      cpu_busy = 1'b0;

      // sweep drain length with request dropped on acknowledge
      for (int d = 0; d <= 8; d++) run_txn(d, 1'b0);

      // sweep drain length with request held: one idle cycle then retake (R8)
      for (int d = 0; d <= 8; d++) begin
         run_txn(d, 1'b1);
         do_reset();
      end

      // R1: reset in the middle of an access
      dbg_req = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
      chk("R5", "grant before mid reset", bus_sel_dbg, 1'b1);
      do_reset();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule